// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Multiplier

This block multiplies two IEEE 754 binary32 operands in a four-stage pipeline and can take a new operand pair on every clock. The stages are: split each operand into its fields, compute sign, exponent and mantissa product side by side, normalize, then classify and pack. Each result comes with a 3-bit status code. The product fraction is truncated and never rounded. An operand whose exponent field is zero counts as zero. Denormal, infinity and NaN encodings are outside the block's scope.

A qualifier bit travels with each operation through the pipeline, so a caller pairs results with requests by counting cycles alone. The exponent and fraction widths are parameters. Setting them to 11 and 52 gives a binary64 multiplier with bias 1023 and 53-bit mantissas.

Top module: `fp_mul_pipe`

## Requirements
- R1: When `inValid` is high at a rising edge, `outValid` is high after exactly 4 rising edges, with that operation's result on `product`/`status`. One operation is accepted per clock, back to back.
- R2: The sign bit of `product` (bit 31) is the XOR of the sign bits of `opA` and `opB`. This holds for zero, underflow and overflow results too.
- R3: The result's biased exponent is expA + expB − 127. It is then raised by 1 when the 48-bit mantissa product has bit 47 set, meaning the product lies in [2,4).
- R4: The 23-bit fraction of a normal result is taken by truncation: product bits 46:24 when bit 47 is set, otherwise bits 45:23. The hidden bit is dropped.
- R5: When either operand has exponent field 0, the result is a zero carrying the R2 sign, with status 000.
- R6: When the adjusted exponent exceeds 254, status is 001 (overflow). `product` is then the R2 sign, exponent field 0xFF and fraction 0.
- R7: When the adjusted exponent is 0 or negative, status is 010 (underflow) and `product` is a zero carrying the R2 sign.
- R8: Every other result has status 011 (normal) and is packed as {sign, exponent[7:0], fraction}.
- R9: While reset is held, and after it is released, `outValid` is 0 and both `product` and `status` read 0.
- R10: In a cycle with `outValid` low, `product` and `status` keep the value they had in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Qualifies `opA`/`opB` in this cycle |
| opA | input | 32 | First binary32 operand |
| opB | input | 32 | Second binary32 operand |
| outValid | output | 1 | Qualifies `product`/`status` |
| product | output | 32 | Packed binary32 result |
| status | output | 3 | 000 zero, 001 overflow, 010 underflow, 011 normal |

## Verification
Each result is due exactly four rising edges after the edge that accepts its operands. The bench records the cycle number when it drives a pair and, for each result, checks that the cycle counter has advanced by exactly four. Results are compared in issue order against expected words worked out from the requirements, so a result that arrives early, late or out of order is reported. Idle cycles between results are checked for output hold. Boundary pairs cover adjusted exponents of 254/255 and 0/1, including cases where the normalization increment alone moves the result across the limit.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  // Fixed depth of the pipeline, in clock edges from accept to result.
  localparam int unsigned PIPE_LATENCY = 4;

  typedef enum logic [2:0] {
    ST_ZERO      = 3'b000,
    ST_OVERFLOW  = 3'b001,
    ST_UNDERFLOW = 3'b010,
    ST_NORMAL    = 3'b011
  } fpStatus_e;

  // Per-stage load strobes issued by the control to the datapath.
  typedef struct packed {
    logic unpackEn;
    logic arithEn;
    logic normEn;
    logic packEn;
  } stageCtl_t;

endpackage

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output stageCtl_t ctl,
  output logic      outValid
);

  localparam int unsigned LAT = PIPE_LATENCY;

  logic [LAT-1:0] vldPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vldPipe <= '0;
    else       vldPipe <= {vldPipe[LAT-2:0], inValid};
  end

  always_comb begin
    ctl.unpackEn = inValid;
    ctl.arithEn  = vldPipe[0];
    ctl.normEn   = vldPipe[1];
    ctl.packEn   = vldPipe[2];
  end

  assign outValid = vldPipe[LAT-1];

endmodule

// File: rtl/fpm_unpack.sv
module fpm_unpack #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      en,
  input  logic [EXP_W+FRAC_W:0]     word,
  output logic                      sign,
  output logic [EXP_W-1:0]          expo,
  output logic [FRAC_W:0]           mant,
  output logic                      isZero
);

  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0] expField;
  assign expField = word[WORD_W-2 -: EXP_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sign   <= 1'b0;
      expo   <= '0;
      mant   <= '0;
      isZero <= 1'b0;
    end else if (en) begin
      sign   <= word[WORD_W-1];
      expo   <= expField;
      mant   <= {1'b1, word[FRAC_W-1:0]};
      isZero <= (expField == '0);
    end
  end

endmodule

// File: rtl/fpm_datapath.sv
module fpm_datapath
  import fpm_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  stageCtl_t             ctl,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  output logic [EXP_W+FRAC_W:0] product,
  output logic [2:0]            status
);

  localparam int unsigned WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int unsigned MANT_W  = FRAC_W + 1;
  localparam int unsigned PROD_W  = 2 * MANT_W;
  localparam int unsigned EXT_W   = EXP_W + 2;
  localparam int unsigned BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int unsigned EXP_MAX = (1 << EXP_W) - 2;

  // ---------------- stage 1: unpack both operands ----------------
  logic [1:0][WORD_W-1:0] opIn;
  logic [1:0]             uSign;
  logic [1:0][EXP_W-1:0]  uExp;
  logic [1:0][MANT_W-1:0] uMant;
  logic [1:0]             uZero;

  assign opIn = {opB, opA};

  for (genvar g = 0; g < 2; g++) begin : g_unpack
    fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp (
      .clk    (clk),
      .rstN   (rstN),
      .en     (ctl.unpackEn),
      .word   (opIn[g]),
      .sign   (uSign[g]),
      .expo   (uExp[g]),
      .mant   (uMant[g]),
      .isZero (uZero[g])
    );
  end

  // ---------------- stage 2: sign, exponent, mantissa product ----------------
  logic              aSign;
  logic [EXT_W-1:0]  aExp;
  logic [PROD_W-1:0] aProd;
  logic              aZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aSign <= 1'b0;
      aExp  <= '0;
      aProd <= '0;
      aZero <= 1'b0;
    end else if (ctl.arithEn) begin
      aSign <= uSign[0] ^ uSign[1];
      aExp  <= EXT_W'(uExp[0]) + EXT_W'(uExp[1]) - EXT_W'(BIAS);
      aProd <= PROD_W'(uMant[0]) * PROD_W'(uMant[1]);
      aZero <= uZero[0] | uZero[1];
    end
  end

  // ---------------- stage 3: normalize ----------------
  logic              prodTop;
  logic [PROD_W-1:0] aligned;
  logic [FRAC_W-1:0] nFracNext;
  logic [EXT_W-1:0]  nExpNext;

  assign prodTop   = aProd[PROD_W-1];
  assign aligned   = prodTop ? (aProd >> MANT_W) : (aProd >> (MANT_W - 1));
  assign nFracNext = FRAC_W'(aligned);
  assign nExpNext  = prodTop ? (aExp + EXT_W'(1)) : aExp;

  logic              nSign;
  logic [EXT_W-1:0]  nExp;
  logic [FRAC_W-1:0] nFrac;
  logic              nZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nSign <= 1'b0;
      nExp  <= '0;
      nFrac <= '0;
      nZero <= 1'b0;
    end else if (ctl.normEn) begin
      nSign <= aSign;
      nExp  <= nExpNext;
      nFrac <= nFracNext;
      nZero <= aZero;
    end
  end

  // ---------------- stage 4: classify and pack ----------------
  logic              expNeg;
  logic              expLow;
  logic              expHigh;
  fpStatus_e         stNext;
  logic [WORD_W-1:0] resNext;

  assign expNeg  = nExp[EXT_W-1];
  assign expLow  = expNeg || (nExp == '0);
  assign expHigh = !expNeg && (nExp > EXT_W'(EXP_MAX));

  always_comb begin
    if (nZero) begin
      stNext  = ST_ZERO;
      resNext = {nSign, {(WORD_W-1){1'b0}}};
    end else if (expHigh) begin
      stNext  = ST_OVERFLOW;
      resNext = {nSign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (expLow) begin
      stNext  = ST_UNDERFLOW;
      resNext = {nSign, {(WORD_W-1){1'b0}}};
    end else begin
      stNext  = ST_NORMAL;
      resNext = {nSign, nExp[EXP_W-1:0], nFrac};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      product <= '0;
      status  <= ST_ZERO;
    end else if (ctl.packEn) begin
      product <= resNext;
      status  <= stNext;
    end
  end

endmodule

// File: rtl/fp_mul_pipe.sv
module fp_mul_pipe
  import fpm_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  output logic                  outValid,
  output logic [EXP_W+FRAC_W:0] product,
  output logic [2:0]            status
);

  stageCtl_t ctl;

  fpm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctl      (ctl),
    .outValid (outValid)
  );

  fpm_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .opA     (opA),
    .opB     (opB),
    .product (product),
    .status  (status)
  );

endmodule

// File: rtl/fpm_checker.sv
module fpm_checker
  import fpm_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  inValid,
  input logic                  signA,
  input logic                  signB,
  input logic                  outValid,
  input logic [EXP_W+FRAC_W:0] product,
  input logic [2:0]            status
);

  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;

  // Edges seen since reset release, saturating at the pipeline depth.
  logic [2:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            sinceRst <= '0;
    else if (sinceRst < 3'(PIPE_LATENCY)) sinceRst <= sinceRst + 3'd1;
  end

  a_r1_fixed_latency: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'(PIPE_LATENCY)) |-> (outValid == $past(inValid, 4)));

  a_r2_sign_xor: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'(PIPE_LATENCY) && outValid)
      |-> (product[WORD_W-1] == ($past(signA, 4) ^ $past(signB, 4))));

  a_r5_zero_shape: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && status == ST_ZERO) |-> (product[WORD_W-2:0] == '0));

  a_r6_overflow_shape: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && status == ST_OVERFLOW)
      |-> (product[WORD_W-2 -: EXP_W] == '1 && product[FRAC_W-1:0] == '0));

  a_r7_underflow_shape: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && status == ST_UNDERFLOW) |-> (product[WORD_W-2:0] == '0));

  a_r8_normal_exp_range: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && status == ST_NORMAL)
      |-> (product[WORD_W-2 -: EXP_W] != '0 && product[WORD_W-2 -: EXP_W] != '1));

  a_r8_status_legal: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (status <= 3'b011));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 3'd0 && !outValid) |-> ($stable(product) && $stable(status)));

endmodule

bind fp_mul_pipe fpm_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .signA    (opA[EXP_W+FRAC_W]),
  .signB    (opB[EXP_W+FRAC_W]),
  .outValid (outValid),
  .product  (product),
  .status   (status)
);

// File: tb/sim_fp_mul_pipe.sv
module sim_fp_mul_pipe;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        outValid;
  logic [31:0] product;
  logic [2:0]  status;

  always #4 clk = ~clk;

  fp_mul_pipe u0 (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opA      (opA),
    .opB      (opB),
    .outValid (outValid),
    .product  (product),
    .status   (status)
  );

  int nCmp = 0;
  int nBad = 0;
  int cyc  = 0;
  bit monOn = 1'b0;
  bit done  = 1'b0;

  logic [34:0] expQ[$];
  int          issueQ[$];
  string       tagQ[$];
  logic [31:0] lastProd = '0;
  logic [2:0]  lastStat = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Expected result from the requirements: {status, product}.
  function automatic logic [34:0] refMul(input logic [31:0] a, input logic [31:0] b);
    logic        s;
    int          e;
    logic [47:0] p;
    logic [22:0] f;
    s = a[31] ^ b[31];
    if (a[30:23] == 0 || b[30:23] == 0) return {3'b000, s, 31'd0};
    p = {24'd0, 1'b1, a[22:0]} * {24'd0, 1'b1, b[22:0]};
    e = int'(a[30:23]) + int'(b[30:23]) - 127;
    if (p[47]) begin f = p[46:24]; e = e + 1; end
    else       f = p[45:23];
    if (e > 254) return {3'b001, s, 8'hFF, 23'd0};
    if (e <= 0)  return {3'b010, s, 31'd0};
    return {3'b011, s, e[7:0], f};
  endfunction

  task automatic issueExp(input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] expProd, input logic [2:0] expStat,
                          input string tag);
    @(negedge clk);
    inValid = 1'b1; opA = a; opB = b;
    expQ.push_back({expStat, expProd});
    issueQ.push_back(cyc);
    tagQ.push_back(tag);
  endtask

  task automatic issueRef(input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [34:0] r;
    r = refMul(a, b);
    issueExp(a, b, r[31:0], r[34:32], tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      opA = 32'hDEAD_BEEF; opB = 32'h1234_5678;
    end
  endtask

  // Scoreboard monitor: results due 4 edges after their accept edge.
  always @(negedge clk) begin
    if (monOn) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check("R1", "unexpected result", 64'(outValid), 64'(0));
        end else begin
          logic [34:0] e;
          int          t0;
          string       tg;
          e  = expQ.pop_front();
          t0 = issueQ.pop_front();
          tg = tagQ.pop_front();
          check("R1", "latency", 64'(cyc - t0), 64'(4));
          check(tg, "product", 64'(product), 64'(e[31:0]));
          check(tg, "status", 64'(status), 64'(e[34:32]));
        end
        lastProd = product;
        lastStat = status;
      end else begin
        check("R10", "idle hold", 64'({status, product}), 64'({lastStat, lastProd}));
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      nBad++;
      $display("FAIL R1 watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    check("R9", "outValid in reset", 64'(outValid), 64'(0));
    rstN = 1'b1;
    @(negedge clk);
    check("R9", "outValid after reset", 64'(outValid), 64'(0));
    check("R9", "product after reset", 64'(product), 64'(0));
    check("R9", "status after reset", 64'(status), 64'(0));
    monOn = 1'b1;

    // Main function and sign (R2, R3, R8)
    issueExp(32'h4000_0000, 32'h4040_0000, 32'h40C0_0000, 3'b011, "R8");
    issueExp(32'hC000_0000, 32'h4040_0000, 32'hC0C0_0000, 3'b011, "R2");
    issueExp(32'hC000_0000, 32'hC040_0000, 32'h40C0_0000, 3'b011, "R2");
    // Product in [2,4): exponent raised (R3)
    issueExp(32'h3FC0_0000, 32'h3FC0_0000, 32'h4010_0000, 3'b011, "R3");
    // Truncation, not rounding (R4)
    issueExp(32'h3F80_0001, 32'h3FC0_0001, 32'h3FC0_0002, 3'b011, "R4");
    issueExp(32'h3FFF_FFFF, 32'h3FFF_FFFF, 32'h407F_FFFE, 3'b011, "R4");
    idle(2);
    // Zero operands (R5)
    issueExp(32'h0000_0000, 32'h4040_0000, 32'h0000_0000, 3'b000, "R5");
    issueExp(32'h8000_0000, 32'h4040_0000, 32'h8000_0000, 3'b000, "R5");
    issueExp(32'hC040_0000, 32'h0000_0000, 32'h8000_0000, 3'b000, "R5");
    // Overflow boundary (R6)
    issueExp(32'h7E80_0000, 32'h4000_0000, 32'h7F00_0000, 3'b011, "R6");
    issueExp(32'h7F00_0000, 32'h4000_0000, 32'h7F80_0000, 3'b001, "R6");
    issueExp(32'hFF00_0000, 32'h7F00_0000, 32'hFF80_0000, 3'b001, "R6");
    issueExp(32'h7F40_0000, 32'h3FC0_0000, 32'h7F80_0000, 3'b001, "R6");
    idle(1);
    // Underflow boundary (R7)
    issueExp(32'h0080_0000, 32'h3F80_0000, 32'h0080_0000, 3'b011, "R7");
    issueExp(32'h0080_0000, 32'h3F00_0000, 32'h0000_0000, 3'b010, "R7");
    issueExp(32'h8080_0000, 32'h3F00_0000, 32'h8000_0000, 3'b010, "R7");
    issueExp(32'h0080_0000, 32'h0080_0000, 32'h0000_0000, 3'b010, "R7");
    issueExp(32'h00C0_0000, 32'h3F40_0000, 32'h0090_0000, 3'b011, "R7");
    idle(5);

    // Mixed traffic, mostly back to back (R1, R3, R4, R8)
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      logic [31:0] b;
      a = $urandom();
      b = $urandom();
      if (a[30:23] == 8'hFF) a[30:23] = 8'hFE;
      if (b[30:23] == 8'hFF) b[30:23] = 8'hFE;
      if (i % 3 == 0) begin
        a[30:23] = 8'd100 + 8'(i % 50);
        b[30:23] = 8'd110 + 8'(i % 40);
      end
      issueRef(a, b, "R3");
      if ($urandom() % 5 == 0) idle(1 + int'($urandom() % 3));
    end
    idle(1);

    for (int w = 0; w < 40 && expQ.size() != 0; w++) @(negedge clk);
    check("R1", "results outstanding", 64'(expQ.size()), 64'(0));
    idle(3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule